// File: doc/BRIEF.md
# Multi-Cycle Eight-Opcode RISC Core

This block is a compact multi-cycle processor for a 32-bit, word-addressed instruction set of eight opcodes and eight general registers. Each instruction walks through a small controller state machine: the word at the program counter is fetched and the PC is advanced, the instruction is decoded while both source registers are read, the ALU works on the operands, memory is accessed when the opcode needs it, and a result is written back. Each opcode leaves the sequence as soon as its work is done, so short instructions take fewer cycles.

Instructions and data share one memory port: a word address, write data, a write strobe, and read data that returns one cycle after the address is presented. A `halted` output reports that a halt instruction has been decoded; after that the core stays idle until reset. A combinational debug port reads any register by index, so a test or a monitor can observe the architectural state without disturbing execution.

The datapath consists of the register file (register 0 fixed at zero), a 16-to-32-bit sign extender, an ALU with add and NOR, the PC, instruction and operand registers, and the controller.

Top module: `mc_core`

## Requirements
- R1: While reset is asserted and right after it, the PC is 0, so the first fetch address is 0. `halted` and `mem_we` are low, and every register reads 0 on the debug port.
- R2: Instruction fields are opcode = bits 24:22, first source (A) = bits 21:19, second source/target (B) = bits 18:16, destination = bits 2:0, and offset = bits 15:0. The offset is sign-extended by copying bit 15 into bits 31:16. Opcodes: 0 add, 1 nor, 2 load, 3 store, 4 branch-if-equal, 5 jump-and-link, 6 halt, 7 no-op.
- R3: add writes A+B (mod 2^32) to the destination register. nor writes ~(A|B) to the destination register.
- R4: load writes memory[A+offset] into register B. store writes register B to memory[A+offset]. Effective addresses wrap modulo 2^32.
- R5: branch-if-equal sets PC to PC+1+offset when A equals B. Otherwise PC becomes PC+1.
- R6: jump-and-link writes PC+1 into register B and sets PC to the value A held before the write. This holds even when A and B name the same register.
- R7: Register 0 always reads 0. Writes to it by load, add or jump-and-link are discarded.
- R8: Cycle cost per instruction: no-op 2, branch 3, add/nor/store/jump-and-link 4, load 5, and halt 2 cycles until `halted` is high.
- R9: Once `halted` rises it stays high until reset. While it is high, `mem_we` stays low and `mem_addr` does not change. A new reset restarts execution from address 0.
- R10: `mem_we` is high for exactly one cycle per store and never for any other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W | Word address for fetch, load or store |
| mem_wdata | output | XLEN | Store data |
| mem_we | output | 1 | Write strobe for the addressed word |
| mem_rdata | input | XLEN | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has been decoded |
| dbg_sel | input | log2(NREG) | Register index for the debug read |
| dbg_data | output | XLEN | Contents of the selected register |

## Verification
The bench checks sign extension with a load whose negative offset wraps the base address to zero. A core that zero-extends the offset would instead address a word above the 256-word window and load a poison value. Taken and untaken branches check the PC+1+offset target; an off-by-one there executes a planted load that must stay skipped. A jump-and-link whose source and target are the same register checks that the old value is used as the jump target; using the new value sends the program to the wrong address. Register 0 is used as a load target and an add destination, and the cycle count to halt is compared per program, so a missing early exit shows up as extra cycles.

// File: rtl/core_pkg.sv
package core_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_NOR   = 3'd1,
        OP_LOAD  = 3'd2,
        OP_STORE = 3'd3,
        OP_BEQ   = 3'd4,
        OP_JLINK = 3'd5,
        OP_HALT  = 3'd6,
        OP_NOP   = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_WB,
        ST_STOP
    } state_e;

    typedef enum logic {
        ALU_ADD,
        ALU_NOR
    } alu_op_e;

    localparam int OPC_LSB = 22;
    localparam int OPC_W   = 3;
    localparam int RA_LSB  = 19;
    localparam int RB_LSB  = 16;
    localparam int RD_LSB  = 0;
    localparam int OFF_W   = 16;

endpackage

// File: rtl/core_sext.sv
module core_sext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  val_in,
    output logic [OUT_W-1:0] val_out
);
    localparam int EXT_W = OUT_W - IN_W;

    generate
        if (EXT_W > 0) begin : g_ext
            assign val_out = {{EXT_W{val_in[IN_W-1]}}, val_in};
        end else begin : g_pass
            assign val_out = val_in[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] opnd_x,
    input  logic [W-1:0] opnd_y,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    output logic [W-1:0] result,
    output logic         equal
);
    always_comb begin
        unique case (op)
            ALU_NOR: result = ~(opnd_x | opnd_y);
            default: result = opnd_x + opnd_y;
        endcase
        equal = (cmp_a == cmp_b);
    end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int W    = 32,
    parameter int N    = 8,
    localparam int AW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rsel_a,
    input  logic [AW-1:0] rsel_b,
    output logic [W-1:0]  rval_a,
    output logic [W-1:0]  rval_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_sel,
    input  logic [W-1:0]  wr_val,
    input  logic [AW-1:0] peek_sel,
    output logic [W-1:0]  peek_val
);
    logic [N*W-1:0] bank;

    generate
        for (genvar i = 0; i < N; i++) begin : g_reg
            if (i == 0) begin : g_zero
                assign bank[W-1:0] = '0;
            end else begin : g_store
                logic [W-1:0] val_d;
                logic [W-1:0] val_q;

                always_comb begin
                    val_d = val_q;
                    if (wr_en && (wr_sel == AW'(i))) begin
                        val_d = wr_val;
                    end
                end

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        val_q <= '0;
                    end else begin
                        val_q <= val_d;
                    end
                end

                assign bank[i*W +: W] = val_q;
            end
        end
    endgenerate

    assign rval_a   = bank[rsel_a*W +: W];
    assign rval_b   = bank[rsel_b*W +: W];
    assign peek_val = bank[peek_sel*W +: W];
endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
    import core_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 16,
    parameter int RSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              mem_we,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              halted,
    output logic [RSEL_W-1:0] rf_sel_a,
    output logic [RSEL_W-1:0] rf_sel_b,
    input  logic [XLEN-1:0]   rf_val_a,
    input  logic [XLEN-1:0]   rf_val_b,
    output logic              rf_we,
    output logic [RSEL_W-1:0] rf_wsel,
    output logic [XLEN-1:0]   rf_wval,
    output alu_op_e           alu_op,
    output logic [XLEN-1:0]   alu_x,
    output logic [XLEN-1:0]   alu_y,
    output logic [XLEN-1:0]   alu_ca,
    output logic [XLEN-1:0]   alu_cb,
    input  logic [XLEN-1:0]   alu_res,
    input  logic              alu_eq,
    output logic [OFF_W-1:0]  imm_raw,
    input  logic [XLEN-1:0]   imm_ext
);
    typedef struct packed {
        state_e          st;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] res;
    } ctrl_t;

    ctrl_t q, d;

    logic [XLEN-1:0]   instr;
    opcode_e           opc;
    logic [RSEL_W-1:0] fld_a;
    logic [RSEL_W-1:0] fld_b;
    logic [RSEL_W-1:0] fld_d;

    // In decode the word arrives straight from memory; later states use IR.
    always_comb begin
        instr = (q.st == ST_DECODE) ? mem_rdata : q.ir;
        opc   = opcode_e'(instr[OPC_LSB +: OPC_W]);
        fld_a = instr[RA_LSB +: RSEL_W];
        fld_b = instr[RB_LSB +: RSEL_W];
        fld_d = instr[RD_LSB +: RSEL_W];
    end

    always_comb begin
        d         = q;
        mem_addr  = q.pc[ADDR_W-1:0];
        mem_wdata = q.opb;
        mem_we    = 1'b0;
        halted    = 1'b0;
        rf_sel_a  = fld_a;
        rf_sel_b  = fld_b;
        rf_we     = 1'b0;
        rf_wsel   = fld_d;
        rf_wval   = q.res;
        alu_op    = ALU_ADD;
        alu_x     = q.opa;
        alu_y     = imm_ext;
        alu_ca    = q.opa;
        alu_cb    = q.opb;
        imm_raw   = instr[OFF_W-1:0];

        unique case (q.st)
            ST_FETCH: begin
                d.pc = q.pc + XLEN'(1);
                d.st = ST_DECODE;
            end

            ST_DECODE: begin
                d.ir  = mem_rdata;
                d.opa = rf_val_a;
                d.opb = rf_val_b;
                case (opc)
                    OP_HALT: d.st = ST_STOP;
                    OP_NOP:  d.st = ST_FETCH;
                    default: d.st = ST_EXEC;
                endcase
            end

            ST_EXEC: begin
                case (opc)
                    OP_ADD, OP_NOR: begin
                        alu_op = (opc == OP_NOR) ? ALU_NOR : ALU_ADD;
                        alu_y  = q.opb;
                        d.res  = alu_res;
                        d.st   = ST_WB;
                    end
                    OP_LOAD, OP_STORE: begin
                        d.res = alu_res;
                        d.st  = ST_MEM;
                    end
                    OP_BEQ: begin
                        alu_x = q.pc;
                        if (alu_eq) begin
                            d.pc = alu_res;
                        end
                        d.st = ST_FETCH;
                    end
                    OP_JLINK: begin
                        d.res = q.pc;
                        d.pc  = q.opa;
                        d.st  = ST_WB;
                    end
                    default: d.st = ST_FETCH;
                endcase
            end

            ST_MEM: begin
                mem_addr = q.res[ADDR_W-1:0];
                if (opc == OP_STORE) begin
                    mem_we = 1'b1;
                    d.st   = ST_FETCH;
                end else begin
                    d.st = ST_WB;
                end
            end

            ST_WB: begin
                rf_we = 1'b1;
                case (opc)
                    OP_LOAD: begin
                        rf_wsel = fld_b;
                        rf_wval = mem_rdata;
                    end
                    OP_JLINK: begin
                        rf_wsel = fld_b;
                    end
                    default: ;
                endcase
                d.st = ST_FETCH;
            end

            ST_STOP: begin
                halted = 1'b1;
            end

            default: d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_FETCH;
            q.pc  <= '0;
            q.ir  <= '0;
            q.opa <= '0;
            q.opb <= '0;
            q.res <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mc_core.sv
module mc_core
    import core_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 16,
    parameter int NREG   = 8,
    localparam int RSEL_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              mem_we,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              halted,
    input  logic [RSEL_W-1:0] dbg_sel,
    output logic [XLEN-1:0]   dbg_data
);
    logic [RSEL_W-1:0] rf_sel_a, rf_sel_b, rf_wsel;
    logic [XLEN-1:0]   rf_val_a, rf_val_b, rf_wval;
    logic              rf_we;
    alu_op_e           alu_op;
    logic [XLEN-1:0]   alu_x, alu_y, alu_ca, alu_cb, alu_res;
    logic              alu_eq;
    logic [OFF_W-1:0]  imm_raw;
    logic [XLEN-1:0]   imm_ext;

    core_ctrl #(.XLEN(XLEN), .ADDR_W(ADDR_W), .RSEL_W(RSEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .halted(halted),
        .rf_sel_a(rf_sel_a), .rf_sel_b(rf_sel_b),
        .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
        .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wval(rf_wval),
        .alu_op(alu_op), .alu_x(alu_x), .alu_y(alu_y),
        .alu_ca(alu_ca), .alu_cb(alu_cb),
        .alu_res(alu_res), .alu_eq(alu_eq),
        .imm_raw(imm_raw), .imm_ext(imm_ext)
    );

    core_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rsel_a(rf_sel_a), .rsel_b(rf_sel_b),
        .rval_a(rf_val_a), .rval_b(rf_val_b),
        .wr_en(rf_we), .wr_sel(rf_wsel), .wr_val(rf_wval),
        .peek_sel(dbg_sel), .peek_val(dbg_data)
    );

    core_alu #(.W(XLEN)) u_alu (
        .op(alu_op), .opnd_x(alu_x), .opnd_y(alu_y),
        .cmp_a(alu_ca), .cmp_b(alu_cb),
        .result(alu_res), .equal(alu_eq)
    );

    core_sext #(.IN_W(OFF_W), .OUT_W(XLEN)) u_sext (
        .val_in(imm_raw), .val_out(imm_ext)
    );
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 16,
    parameter int RSEL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              halted,
    input logic [RSEL_W-1:0] dbg_sel,
    input logic [XLEN-1:0]   dbg_data
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!mem_we && !halted && mem_addr == '0));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9
    halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R9
    halt_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(mem_addr));

    // R10
    store_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R7
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_sel == '0) |-> (dbg_data == '0));
endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W), .RSEL_W(RSEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .halted(halted), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
);

// File: tb/tb_mc_core.sv
module tb_mc_core;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam logic [2:0] I_ADD = 3'd0, I_NOR = 3'd1, I_LD = 3'd2, I_ST = 3'd3,
                           I_BEQ = 3'd4, I_JL = 3'd5, I_HALT = 3'd6, I_NOP = 3'd7;

    logic          clk = 0;
    logic          rst_n = 1;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_we;
    logic [31:0]   mem_rdata;
    logic          halted;
    logic [2:0]    dbg_sel = 0;
    logic [31:0]   dbg_data;

    logic [31:0] mem [256];
    int n_chk = 0, n_fail = 0, we_cnt = 0;

    mc_core #(.XLEN(32), .ADDR_W(AW), .NREG(8)) dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: 256 words; reads above the window return a poison word.
    always @(posedge clk) begin
        if (mem_we && rst_n) begin
            we_cnt <= we_cnt + 1;
            if (mem_addr[AW-1:8] == 0) mem[mem_addr[7:0]] <= mem_wdata;
        end
        mem_rdata <= (mem_addr[AW-1:8] == 0) ? mem[mem_addr[7:0]] : 32'hDEAD_BEEF;
    end

    function automatic logic [31:0] enc(input logic [2:0] op, input logic [2:0] ra,
                                        input logic [2:0] rb, input logic [15:0] f);
        return {7'd0, op, ra, rb, f};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic reg_val(input int idx, output logic [31:0] v);
        dbg_sel = 3'(idx);
        #1;
        v = dbg_data;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        we_cnt = 0;
        rst_n = 1;
    endtask

    task automatic run_prog(input string tag, input int exp_cycles);
        int n = 0;
        while (!halted && n < 300) begin
            @(posedge clk);
            n++;
            #1;
        end
        chk(tag, 32'(n), 32'(exp_cycles));
    endtask

    typedef logic [98:0] vec_t;
    localparam vec_t VEC [6] = '{
        {I_ADD, 32'd5,        32'd3,        32'd8},
        {I_ADD, 32'hFFFFFFFF, 32'd1,        32'd0},
        {I_ADD, 32'h7FFFFFFF, 32'd1,        32'h80000000},
        {I_NOR, 32'd0,        32'd0,        32'hFFFFFFFF},
        {I_NOR, 32'hF0F0F0F0, 32'h0F0F0F00, 32'h0000000F},
        {I_NOR, 32'hFFFF0000, 32'h0000FFFF, 32'h0}
    };

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, a0;

        // R1 reset state
        #1 rst_n = 0;
        clear_mem();
        repeat (2) @(negedge clk);
        chk("R1 halted in reset", 32'(halted), 0);
        chk("R1 mem_we in reset", 32'(mem_we), 0);
        chk("R1 fetch address", 32'(mem_addr), 0);
        for (int r = 0; r < 8; r++) begin
            reg_val(r, v);
            chk("R1 register cleared", v, 0);
        end

        // R3 / R8 table of add and nor cases
        foreach (VEC[k]) begin
            clear_mem();
            mem[0] = enc(I_LD, 0, 1, 16'd100);
            mem[1] = enc(I_LD, 0, 2, 16'd101);
            mem[2] = enc(VEC[k][98:96], 1, 2, 16'd3);
            mem[3] = enc(I_HALT, 0, 0, 0);
            mem[100] = VEC[k][95:64];
            mem[101] = VEC[k][63:32];
            do_reset();
            run_prog("R8 alu program cycles", 16);
            reg_val(3, v);
            chk("R3 alu result", v, VEC[k][31:0]);
        end

        // R4 / R2 load, store, negative offset
        clear_mem();
        mem[0] = enc(I_LD, 0, 1, 16'd100);
        mem[1] = enc(I_LD, 1, 2, 16'd96);
        mem[2] = enc(I_ST, 1, 2, 16'd200);
        mem[3] = enc(I_LD, 1, 3, 16'hFFFB);
        mem[4] = enc(I_HALT, 0, 0, 0);
        mem[100] = 32'd5;
        mem[101] = 32'h0000_1234;
        do_reset();
        run_prog("R8 load/store cycles", 21);
        reg_val(2, v);
        chk("R4 load with base", v, 32'h1234);
        chk("R4 store to memory", mem[205], 32'h1234);
        reg_val(3, v);
        chk("R2 sign-extended negative offset", v, enc(I_LD, 0, 1, 16'd100));
        chk("R10 one write strobe", 32'(we_cnt), 1);

        // R9 halted state holds
        a0 = 32'(mem_addr);
        for (int c = 0; c < 20; c++) begin
            @(posedge clk);
            #1;
            if (!halted || mem_we || 32'(mem_addr) != a0) begin
                chk("R9 halt hold", {halted, mem_we, 8'(mem_addr)}, {1'b1, 1'b0, 8'(a0)});
            end
        end
        chk("R9 halted persists", 32'(halted), 1);
        chk("R10 no stray writes", 32'(we_cnt), 1);

        // R5 branches
        clear_mem();
        mem[0] = enc(I_LD, 0, 1, 16'd100);
        mem[1] = enc(I_LD, 0, 2, 16'd100);
        mem[2] = enc(I_BEQ, 1, 2, 16'd2);
        mem[3] = enc(I_LD, 0, 4, 16'd100);
        mem[4] = enc(I_LD, 0, 4, 16'd100);
        mem[5] = enc(I_BEQ, 1, 0, 16'd1);
        mem[6] = enc(I_NOP, 0, 0, 0);
        mem[7] = enc(I_HALT, 0, 0, 0);
        mem[100] = 32'd7;
        do_reset();
        chk("R9 restart from zero", 32'(mem_addr), 0);
        run_prog("R8 branch program cycles", 20);
        reg_val(4, v);
        chk("R5 taken branch skipped loads", v, 0);
        reg_val(1, v);
        chk("R1 registers reloaded after reset", v, 7);

        // R6 jump-and-link
        clear_mem();
        mem[0] = enc(I_LD, 0, 1, 16'd100);
        mem[1] = enc(I_JL, 1, 2, 0);
        mem[2] = enc(I_LD, 0, 5, 16'd100);
        mem[3] = enc(I_LD, 0, 5, 16'd100);
        mem[4] = enc(I_LD, 0, 3, 16'd101);
        mem[5] = enc(I_JL, 3, 3, 0);
        mem[6] = enc(I_LD, 0, 5, 16'd100);
        mem[7] = enc(I_HALT, 0, 0, 0);
        mem[100] = 32'd4;
        mem[101] = 32'd7;
        do_reset();
        run_prog("R8 jump program cycles", 20);
        reg_val(2, v);
        chk("R6 link value", v, 2);
        reg_val(3, v);
        chk("R6 same-register link", v, 6);
        reg_val(5, v);
        chk("R6 skipped instructions", v, 0);

        // R7 register zero
        clear_mem();
        mem[0] = enc(I_LD, 0, 0, 16'd100);
        mem[1] = enc(I_LD, 0, 1, 16'd100);
        mem[2] = enc(I_ADD, 1, 1, 16'd0);
        mem[3] = enc(I_ADD, 0, 1, 16'd2);
        mem[4] = enc(I_HALT, 0, 0, 0);
        mem[100] = 32'd9;
        do_reset();
        run_prog("R8 zero-reg program cycles", 20);
        reg_val(0, v);
        chk("R7 r0 stays zero", v, 0);
        reg_val(1, v);
        chk("R7 load used zero base", v, 9);
        reg_val(2, v);
        chk("R7 r0 source reads zero", v, 9);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule